// File: doc/BRIEF.md
# Flash Bus Operation Decoder

This block sits between the control pins of a NOR-style memory interface and the internal logic that serves reads and programs the array. A fast free-running clock samples the chip enable, output enable, write enable, address strobe and reset/power-down pins. Each bus cycle is classified into one operating mode, and the data-bus output enable is driven to match. The address and write data are captured on the pin edges that define a bus cycle, so the memory core sees one clean, single-cycle write event for each write cycle.

Short pulses on chip enable and write enable are filtered out by requiring a pin to hold its new level for a parameterised number of samples. With the reset pin low, one configuration input chooses between reset and power-down. Releasing the pin produces a one-cycle pulse that the core uses to clear its status and return its read configuration to asynchronous page reads. In read mode an inactivity counter moves the block into automatic standby while it keeps driving data, unless the burst configuration is selected.

Top module: `flash_busop_front`

## Requirements
- R1: `mode` is always one-hot. The bit positions are: bit0 read, bit1 write, bit2 output disabled, bit3 standby, bit4 reset, bit5 power-down, bit6 automatic standby. It resets to standby, with `dq_oe`=0, `addr_q`=0, `wdata_q`=0 and `wdata_vld`=0.
- R2: Chip enable low, output enable low and write enable high select read (or automatic standby, see R11). Both drive `dq_oe`=1.
- R3: Chip enable low, write enable low and output enable high select write. The write data is captured on the first rising edge of write enable or chip enable, with exactly one `wdata_vld` pulse per write cycle.
- R4: The write address comes from the first rising edge among the address strobe, write enable and chip enable in that cycle. Later edges in the same cycle do not overwrite it.
- R5: A rising edge of the address strobe while chip enable is low captures `addr_in` into `addr_q` for reads.
- R6: Chip enable low with output enable and write enable both high selects output disabled with `dq_oe`=0. With write enable and output enable both low, `illegal` is 1 and the mode is output disabled. A write cycle during which output enable goes low produces no `wdata_vld`.
- R7: Chip enable high with `pe_busy`=0 selects standby. Chip enable high with `pe_busy`=1 selects output disabled. In both cases `dq_oe`=0, whatever output enable and write enable are doing.
- R8: With the reset pin low, the mode is power-down if `cfg_pd`=1 and reset otherwise. `dq_oe`=0 and no write is captured, whatever the other pins do.
- R9: A rising edge of the reset pin gives exactly one `rp_exit` pulse.
- R10: A chip enable or write enable pulse shorter than `GLITCH_CYC` samples changes neither the mode nor any capture.
- R11: In read mode, `IDLE_CYC` cycles without any pin or address change select automatic standby, and `dq_oe` stays 1. With `cfg_burst`=1 the mode stays read. Any address change returns the block to read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| adv_n | input | 1 | Address strobe, address taken on its rising edge |
| rp_n | input | 1 | Reset/power-down pin, active low |
| cfg_pd | input | 1 | 1: reset pin low means power-down; 0: reset |
| cfg_burst | input | 1 | Burst read configured; disables automatic standby |
| pe_busy | input | 1 | Program/erase engine busy |
| addr_in | input | AW | Address bus |
| dq_in | input | DW | Data bus input |
| addr_q | output | AW | Captured address |
| wdata_q | output | DW | Captured write data |
| wdata_vld | output | 1 | One-cycle pulse when write data is captured |
| dq_oe | output | 1 | Data bus output enable |
| mode | output | 7 | One-hot operating mode |
| illegal | output | 1 | Write enable and output enable both low |
| rp_exit | output | 1 | One-cycle pulse on leaving reset/power-down |

## Verification
The bench targets the edge ordering of writes. If chip enable rises before write enable, a design that captures on either edge would pulse `wdata_vld` twice. If the strobe comes before write enable, a design that latches on the last edge would overwrite the address. A write enable pulse held for fewer than the filter threshold must leave the capture count unchanged; a weak filter would record a phantom write. Further checks cover a write aborted by output enable, writes attempted with the reset pin low, the choice between reset and power-down, and automatic standby. For the last, a design that stopped driving data or ignored the burst setting would show up in `dq_oe` or `mode`.

// File: rtl/fbo_pkg.sv
package fbo_pkg;
  localparam int MODE_N  = 7;
  localparam int IX_READ = 0;
  localparam int IX_WR   = 1;
  localparam int IX_DIS  = 2;
  localparam int IX_STBY = 3;
  localparam int IX_RST  = 4;
  localparam int IX_PD   = 5;
  localparam int IX_AUTO = 6;

  localparam int PIN_N   = 5;
  localparam int P_CE    = 0;
  localparam int P_OE    = 1;
  localparam int P_WE    = 2;
  localparam int P_ADV   = 3;
  localparam int P_RP    = 4;

  typedef logic [MODE_N-1:0] mode_t;
endpackage

// File: rtl/fbo_deglitch.sv
module fbo_deglitch #(
  parameter int STABLE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic pin_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
    end
  end

  generate
    if (STABLE_CYC <= 1) begin : g_pass
      assign pin_o = s2_q;
    end else begin : g_filt
      localparam int CW = $clog2(STABLE_CYC + 1);
      logic [CW-1:0] cnt_q, cnt_d;
      logic          flt_q, flt_d;

      always_comb begin
        cnt_d = cnt_q;
        flt_d = flt_q;
        if (s2_q == flt_q) begin
          cnt_d = '0;
        end else if (cnt_q == CW'(STABLE_CYC - 1)) begin
          cnt_d = '0;
          flt_d = s2_q;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
          flt_q <= 1'b1;
        end else begin
          cnt_q <= cnt_d;
          flt_q <= flt_d;
        end
      end

      assign pin_o = flt_q;
    end
  endgenerate
endmodule

// File: rtl/fbo_capture.sv
module fbo_capture #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_f,
  input  logic          oe_f,
  input  logic          we_f,
  input  logic          adv_f,
  input  logic          rp_f,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] dq_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic          wdata_vld,
  output logic          rp_exit
);
  logic ce_p, oe_p, we_p, adv_p, rp_p;
  logic ce_rise, oe_rise, we_rise, adv_rise, rp_rise;
  logic wr_act_q, wr_act_d;
  logic a_done_q, a_done_d;
  logic wr_entry, wr_end;
  logic [AW-1:0] addr_d;
  logic [DW-1:0] wdata_d;
  logic          vld_d;

  assign ce_rise  = ce_f  & ~ce_p;
  assign oe_rise  = oe_f  & ~oe_p;
  assign we_rise  = we_f  & ~we_p;
  assign adv_rise = adv_f & ~adv_p;
  assign rp_rise  = rp_f  & ~rp_p;

  // a write cycle opens only on the cycle both strobes are first seen low
  assign wr_entry = rp_f & ~ce_f & ~we_f & oe_f & (ce_p | we_p);
  assign wr_end   = wr_act_q & (we_rise | ce_rise);

  always_comb begin
    wr_act_d = wr_act_q;
    if (!rp_f || !oe_f)  wr_act_d = 1'b0;
    else if (wr_end)     wr_act_d = 1'b0;
    else if (wr_entry)   wr_act_d = 1'b1;
  end

  always_comb begin
    a_done_d = a_done_q;
    if (rp_f && !ce_f && adv_rise)          a_done_d = 1'b1;
    else if (wr_end || ce_f || oe_rise || !rp_f) a_done_d = 1'b0;
  end

  always_comb begin
    addr_d  = addr_q;
    wdata_d = wdata_q;
    vld_d   = 1'b0;
    if (rp_f && !ce_f && adv_rise) begin
      addr_d = addr_in;
    end else if (wr_end && !a_done_q) begin
      addr_d = addr_in;
    end
    if (wr_end) begin
      wdata_d = dq_in;
      vld_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_p      <= 1'b1;
      oe_p      <= 1'b1;
      we_p      <= 1'b1;
      adv_p     <= 1'b1;
      rp_p      <= 1'b1;
      wr_act_q  <= 1'b0;
      a_done_q  <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      wdata_vld <= 1'b0;
      rp_exit   <= 1'b0;
    end else begin
      ce_p      <= ce_f;
      oe_p      <= oe_f;
      we_p      <= we_f;
      adv_p     <= adv_f;
      rp_p      <= rp_f;
      wr_act_q  <= wr_act_d;
      a_done_q  <= a_done_d;
      addr_q    <= addr_d;
      wdata_q   <= wdata_d;
      wdata_vld <= vld_d;
      rp_exit   <= rp_rise;
    end
  end
endmodule

// File: rtl/fbo_mode.sv
module fbo_mode
  import fbo_pkg::*;
#(
  parameter int AW       = 16,
  parameter int IDLE_CYC = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PIN_N-1:0] pins_f,
  input  logic          cfg_pd,
  input  logic          cfg_burst,
  input  logic          pe_busy,
  input  logic [AW-1:0] addr_in,
  output mode_t         mode_q,
  output logic          illegal_q,
  output logic          dq_oe_q
);
  localparam int IW = $clog2(IDLE_CYC + 1);

  logic [PIN_N-1:0] pins_p;
  logic [AW-1:0]    addr_p;
  logic [IW-1:0]    idle_q, idle_d;
  logic             act, idle_done;
  mode_t            mode_d;
  logic             ill_d, oe_d;
  logic             ce, oe, we, rp;

  assign ce = pins_f[P_CE];
  assign oe = pins_f[P_OE];
  assign we = pins_f[P_WE];
  assign rp = pins_f[P_RP];

  assign act       = (pins_f != pins_p) | (addr_in != addr_p);
  assign idle_done = (idle_q == IW'(IDLE_CYC));

  always_comb begin
    idle_d = idle_q;
    if (act)             idle_d = '0;
    else if (!idle_done) idle_d = idle_q + 1'b1;
  end

  always_comb begin
    mode_d = '0;
    if (!rp) begin
      if (cfg_pd) mode_d[IX_PD]  = 1'b1;
      else        mode_d[IX_RST] = 1'b1;
    end else if (ce) begin
      if (pe_busy) mode_d[IX_DIS]  = 1'b1;
      else         mode_d[IX_STBY] = 1'b1;
    end else if (!we && oe) begin
      mode_d[IX_WR] = 1'b1;
    end else if (we && !oe) begin
      if (idle_done && !cfg_burst) mode_d[IX_AUTO] = 1'b1;
      else                         mode_d[IX_READ] = 1'b1;
    end else begin
      mode_d[IX_DIS] = 1'b1;
    end
  end

  assign ill_d = rp & ~ce & ~we & ~oe;
  assign oe_d  = mode_d[IX_READ] | mode_d[IX_AUTO];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_p    <= '1;
      addr_p    <= '0;
      idle_q    <= '0;
      mode_q    <= mode_t'(1 << IX_STBY);
      illegal_q <= 1'b0;
      dq_oe_q   <= 1'b0;
    end else begin
      pins_p    <= pins_f;
      addr_p    <= addr_in;
      idle_q    <= idle_d;
      mode_q    <= mode_d;
      illegal_q <= ill_d;
      dq_oe_q   <= oe_d;
    end
  end
endmodule

// File: rtl/flash_busop_front.sv
module flash_busop_front
  import fbo_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 16,
  parameter int GLITCH_CYC = 4,
  parameter int IDLE_CYC   = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          adv_n,
  input  logic          rp_n,
  input  logic          cfg_pd,
  input  logic          cfg_burst,
  input  logic          pe_busy,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] dq_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic          wdata_vld,
  output logic          dq_oe,
  output logic [6:0]    mode,
  output logic          illegal,
  output logic          rp_exit
);
  logic [PIN_N-1:0] pins_raw, pins_f;
  mode_t            mode_w;

  assign pins_raw[P_CE]  = ce_n;
  assign pins_raw[P_OE]  = oe_n;
  assign pins_raw[P_WE]  = we_n;
  assign pins_raw[P_ADV] = adv_n;
  assign pins_raw[P_RP]  = rp_n;

  for (genvar i = 0; i < PIN_N; i++) begin : g_pin
    localparam int SC = (i == P_CE || i == P_WE) ? GLITCH_CYC : 1;
    fbo_deglitch #(.STABLE_CYC(SC)) u_dg (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i (pins_raw[i]),
      .pin_o (pins_f[i])
    );
  end

  fbo_capture #(.AW(AW), .DW(DW)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_f      (pins_f[P_CE]),
    .oe_f      (pins_f[P_OE]),
    .we_f      (pins_f[P_WE]),
    .adv_f     (pins_f[P_ADV]),
    .rp_f      (pins_f[P_RP]),
    .addr_in   (addr_in),
    .dq_in     (dq_in),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q),
    .wdata_vld (wdata_vld),
    .rp_exit   (rp_exit)
  );

  fbo_mode #(.AW(AW), .IDLE_CYC(IDLE_CYC)) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .pins_f    (pins_f),
    .cfg_pd    (cfg_pd),
    .cfg_burst (cfg_burst),
    .pe_busy   (pe_busy),
    .addr_in   (addr_in),
    .mode_q    (mode_w),
    .illegal_q (illegal),
    .dq_oe_q   (dq_oe)
  );

  assign mode = mode_w;
endmodule

// File: rtl/fbo_chk.sv
module fbo_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [6:0] mode,
  input logic       wdata_vld,
  input logic       rp_exit,
  input logic       cfg_burst,
  input logic       dq_oe,
  input logic       illegal
);
  p_mode_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mode) == 1);

  p_vld_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wdata_vld |=> !wdata_vld);

  p_illegal_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !dq_oe);

  p_rp_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[4] || mode[5]) |-> !wdata_vld);

  p_exit_after_rp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rp_exit |-> ($past(mode[4]) || $past(mode[5])));

  p_auto_not_burst_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mode[6] |-> !$past(cfg_burst));
endmodule

bind flash_busop_front fbo_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode      (mode),
  .wdata_vld (wdata_vld),
  .rp_exit   (rp_exit),
  .cfg_burst (cfg_burst),
  .dq_oe     (dq_oe),
  .illegal   (illegal)
);

// File: tb/sim_flash_busop_front.sv
`timescale 1ns/1ps
module sim_flash_busop_front;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam logic [6:0] MR = 7'b0000001;
  localparam logic [6:0] MW = 7'b0000010;
  localparam logic [6:0] MD = 7'b0000100;
  localparam logic [6:0] MS = 7'b0001000;
  localparam logic [6:0] MX = 7'b0010000;
  localparam logic [6:0] MP = 7'b0100000;
  localparam logic [6:0] MA = 7'b1000000;
  localparam int NV = 11;
  // {rp_n, ce_n, oe_n, we_n, cfg_pd, pe_busy, exp_illegal, exp_mode}
  localparam logic [13:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,MR},
    {1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,MD},
    {1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,MS},
    {1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,MD},
    {1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,MW},
    {1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,MR},
    {1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,MP},
    {1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,MX},
    {1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,MS},
    {1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,MD},
    {1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,MS}
  };

  logic clk, rst_n;
  logic ce_n, oe_n, we_n, adv_n, rp_n, cfg_pd, cfg_burst, pe_busy;
  logic [AW-1:0] addr_in, addr_q;
  logic [DW-1:0] dq_in, wdata_q;
  logic wdata_vld, dq_oe, illegal, rp_exit;
  logic [6:0] mode;

  int total, bad, wcnt, xcnt, w0, x0;
  logic watch, left_stby;

  flash_busop_front u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .adv_n(adv_n), .rp_n(rp_n), .cfg_pd(cfg_pd), .cfg_burst(cfg_burst),
    .pe_busy(pe_busy), .addr_in(addr_in), .dq_in(dq_in), .addr_q(addr_q),
    .wdata_q(wdata_q), .wdata_vld(wdata_vld), .dq_oe(dq_oe), .mode(mode),
    .illegal(illegal), .rp_exit(rp_exit)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (wdata_vld) wcnt++;
    if (rp_exit)   xcnt++;
    if (watch && mode != MS) left_stby = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic adv_pulse();
    adv_n = 1'b0; wt(3); adv_n = 1'b1; wt(10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0; wcnt = 0; xcnt = 0; watch = 1'b0; left_stby = 1'b0;
    rst_n = 1'b0;
    ce_n = 1; oe_n = 1; we_n = 1; adv_n = 1; rp_n = 1;
    cfg_pd = 0; cfg_burst = 0; pe_busy = 0;
    addr_in = '0; dq_in = '0;
    wt(3);
    // R12-style reset state belongs to R1
    chk(mode == MS, "R1 reset mode", mode, MS);
    chk(!dq_oe && !wdata_vld, "R1 reset dq_oe/vld", {dq_oe, wdata_vld}, 0);
    chk(addr_q == 0 && wdata_q == 0, "R1 reset captures", addr_q, 0);
    rst_n = 1'b1;
    wt(10);
    chk(mode == MS, "R7 idle standby", mode, MS);

    // table walk: R1 R2 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      rp_n = VEC[i][13]; ce_n = VEC[i][12]; oe_n = VEC[i][11]; we_n = VEC[i][10];
      cfg_pd = VEC[i][9]; pe_busy = VEC[i][8];
      wt(12);
      chk(mode == VEC[i][6:0], "R1/R2/R6/R7/R8 table mode", mode, VEC[i][6:0]);
      chk(dq_oe == (VEC[i][0] | VEC[i][6]), "R2/R7/R8 table dq_oe", dq_oe, VEC[i][0] | VEC[i][6]);
      chk(illegal == VEC[i][7], "R6 table illegal", illegal, VEC[i][7]);
    end
    cfg_pd = 0; pe_busy = 0;
    wt(10);

    // R4 strobe first, then write enable
    w0 = wcnt;
    addr_in = 16'h1111; ce_n = 0; wt(10); adv_pulse();
    addr_in = 16'h2222; dq_in = 16'hBEEF; we_n = 0; wt(10);
    chk(mode == MW, "R3 write mode", mode, MW);
    we_n = 1; wt(10);
    chk(addr_q == 16'h1111, "R4 strobe edge kept", addr_q, 16'h1111);
    chk(wdata_q == 16'hBEEF, "R3 data on we rise", wdata_q, 16'hBEEF);
    chk(wcnt == w0 + 1, "R3 one pulse", wcnt - w0, 1);
    ce_n = 1; wt(10);

    // R4 no strobe: address from write enable edge
    addr_in = 16'h3333; dq_in = 16'h1234; ce_n = 0; wt(10);
    we_n = 0; wt(10); we_n = 1; wt(10);
    chk(addr_q == 16'h3333, "R4 we edge address", addr_q, 16'h3333);
    chk(wdata_q == 16'h1234, "R3 data captured", wdata_q, 16'h1234);
    ce_n = 1; wt(10);

    // R3 chip enable rises first, no second capture
    w0 = wcnt;
    addr_in = 16'h4444; dq_in = 16'h5678; ce_n = 0; we_n = 0; wt(10);
    ce_n = 1; wt(10);
    chk(wcnt == w0 + 1 && wdata_q == 16'h5678, "R3 ce edge capture", wdata_q, 16'h5678);
    chk(addr_q == 16'h4444, "R4 ce edge address", addr_q, 16'h4444);
    we_n = 1; wt(10);
    chk(wcnt == w0 + 1, "R3 no second pulse", wcnt - w0, 1);

    // R10 write enable glitch
    w0 = wcnt;
    ce_n = 0; wt(10); dq_in = 16'h9999;
    we_n = 0; wt(2); we_n = 1; wt(12);
    chk(wcnt == w0, "R10 we glitch ignored", wcnt - w0, 0);
    chk(wdata_q == 16'h5678, "R10 data unchanged", wdata_q, 16'h5678);
    ce_n = 1; wt(10);
    // R10 chip enable glitch
    watch = 1'b1; left_stby = 1'b0;
    ce_n = 0; wt(2); ce_n = 1; wt(12);
    watch = 1'b0;
    chk(!left_stby, "R10 ce glitch ignored", left_stby, 0);

    // R6 write aborted by output enable
    w0 = wcnt;
    ce_n = 0; we_n = 0; wt(10);
    oe_n = 0; wt(10);
    chk(illegal && mode == MD, "R6 illegal flagged", {illegal, mode}, {1'b1, MD});
    chk(!dq_oe, "R6 bus floats", dq_oe, 0);
    we_n = 1; wt(10);
    chk(wcnt == w0, "R6 aborted write", wcnt - w0, 0);
    oe_n = 1; ce_n = 1; wt(10);

    // R5 read address and R11 automatic standby
    addr_in = 16'h5A5A; ce_n = 0; oe_n = 0; wt(10); adv_pulse();
    chk(addr_q == 16'h5A5A, "R5 read address", addr_q, 16'h5A5A);
    chk(mode == MR && dq_oe, "R2 read drives", mode, MR);
    wt(40);
    chk(mode == MA, "R11 auto standby", mode, MA);
    chk(dq_oe, "R11 still driving", dq_oe, 1);
    cfg_burst = 1; wt(4);
    chk(mode == MR, "R11 burst blocks", mode, MR);
    cfg_burst = 0; wt(4);
    chk(mode == MA, "R11 auto again", mode, MA);
    addr_in = 16'h0001; wt(4);
    chk(mode == MR, "R11 activity wakes", mode, MR);
    ce_n = 1; oe_n = 1; wt(10);

    // R8 and R9
    w0 = wcnt;
    cfg_pd = 1; ce_n = 0; rp_n = 0; wt(10);
    chk(mode == MP, "R8 power-down", mode, MP);
    we_n = 0; wt(10); we_n = 1; wt(10);
    chk(wcnt == w0, "R8 no write in reset", wcnt - w0, 0);
    oe_n = 0; wt(10);
    chk(!dq_oe && mode == MP, "R8 float in power-down", dq_oe, 0);
    cfg_pd = 0; wt(4);
    chk(mode == MX, "R8 reset selected", mode, MX);
    x0 = xcnt;
    rp_n = 1; wt(10);
    chk(xcnt == x0 + 1, "R9 exit pulse", xcnt - x0, 1);
    chk(mode == MR, "R9 read after exit", mode, MR);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule